// File: doc/BRIEF.md
# Switched I/O Port Selector

This block lets many peripherals share one sixteen-address window of the I/O space. The lowest address of the window holds a shared selection register. Every device on the bus stores whatever identifier the CPU writes there. Only the device whose own configured identifier matches the stored value takes part in the other fifteen addresses, which are called switched ports.

Software probes for a device in two steps. It writes the identifier, then reads the same address. A device that is present and selected returns the bitwise complement of the identifier. When no device is selected, nothing answers the read, and an output-enable signal stays low so that other bus agents remain free to drive the data bus.

The first switched port holds an example extension register. Its bit 0 selects the CPU speed mode and drives an output pin. Its bit 7 shows the level of an external switch and cannot be written. The remaining switched ports are not implemented here. For each of them the block raises a one-hot access strobe that a peripheral function can use. As an option, the block also compares the upper byte of the 16-bit I/O address against a configured value.

Top module: `swio_select`

## Requirements
- R1: After reset the stored identifier is 0, so the block is not selected and reads of the window are not answered, and the speed bit is 1 (normal speed).
- R2: A write to the selection address (low byte 0x40) stores the written byte whatever its value. While the stored byte equals the OWN_ID parameter, `sel_active` is 1 and a read of 0x40 returns the bitwise complement of the stored byte with `rd_valid` 1.
- R3: When the stored identifier differs from OWN_ID, no read in 0x40–0x4F raises `rd_valid`. Whenever `rd_valid` is 0, `rd_data` is 0x00.
- R4: Writing 0x00 or 0xFF to 0x40 leaves the block deselected in the following cycle.
- R5: While the block is selected, a write to 0x41 loads bit 0 of the data into the speed bit (0 = fast, 1 = normal), and `speed_slow` shows the speed bit.
- R6: A write to 0x41 while the block is not selected does not change the speed bit.
- R7: While the block is selected, a read of 0x41 returns the speed bit in bit 0, the level of `ext_switch` in bit 7 (0 = on, 1 = off) and zeros in bits 6:1. Bit 7 of a written byte is ignored.
- R8: While the block is selected, a read or write of address 0x41+k (k = 0..14) raises `port_en[k]` alone in that cycle. When the block is not selected, or the address is outside 0x41–0x4F, `port_en` is all zeros.
- R9: With HI_CHECK = 1, an access whose upper address byte differs from HI_MATCH is ignored completely: it does not store anything, it is not answered, and it raises no strobe.
- R10: With HI_CHECK = 0, the upper address byte has no effect on decoding.
- R11: Writes to addresses outside 0x40–0x4F change neither the stored identifier nor the speed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O address; the low byte selects the port, the high byte is compared when HI_CHECK is 1 |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| ext_switch | input | 1 | External switch level (0 = on, 1 = off) |
| rd_data | output | 8 | Read data, 0x00 when not answering |
| rd_valid | output | 1 | Output enable: the block drives the data bus for this read |
| sel_active | output | 1 | Stored identifier equals OWN_ID |
| speed_slow | output | 1 | CPU speed mode (0 = fast, 1 = normal) |
| port_en | output | 15 | One-hot access strobe for switched ports 0x41..0x4F |

## Verification
The bench builds two instances that receive the same bus traffic. The first uses the defaults: manufacturer-range identifier 8 and no upper-byte decoding. The second uses the device-range identifier 200 and requires an upper byte of 0x12. Because both store every identifier written through an address they decode, a single write can select one instance and deselect the other. This exercises the shared-register behaviour, the address-qualified ignore case and the upper-byte insensitivity in the same run.

// File: rtl/swio_pkg.sv
package swio_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t ID_NONE    = 8'h00;
    localparam byte_t ID_ALL_OFF = 8'hFF;

    localparam int EXT_SPEED_BIT  = 0;
    localparam int EXT_SWITCH_BIT = 7;

    typedef struct packed {
        byte_t dev_id;
    } sel_state_t;

    typedef struct packed {
        logic slow;
    } ext_state_t;

endpackage

// File: rtl/swio_decode.sv
module swio_decode #(
    parameter logic [7:0] WIN_BASE = 8'h40,
    parameter int         NUM_SW   = 15,
    parameter bit         HI_CHECK = 1'b0,
    parameter logic [7:0] HI_MATCH = 8'h00
) (
    input  logic [15:0]       addr,
    output logic              hit_id,
    output logic [NUM_SW-1:0] hit_sw
);
    logic hi_ok;

    // the upper byte only matters when the optional check is built in
    assign hi_ok  = HI_CHECK ? (addr[15:8] == HI_MATCH) : 1'b1;
    assign hit_id = hi_ok && (addr[7:0] == WIN_BASE);

    for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
        localparam logic [7:0] PORT_LO = 8'(WIN_BASE + 8'(k) + 8'd1);
        assign hit_sw[k] = hi_ok && (addr[7:0] == PORT_LO);
    end
endmodule

// File: rtl/swio_ext_reg.sv
module swio_ext_reg
    import swio_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_bit,
    input  logic  ext_switch,
    output logic  slow,
    output byte_t rd_byte
);
    ext_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.slow = wr_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slow <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign slow = st_q.slow;

    always_comb begin
        rd_byte                 = '0;
        rd_byte[EXT_SPEED_BIT]  = st_q.slow;
        rd_byte[EXT_SWITCH_BIT] = ext_switch;
    end
endmodule

// File: rtl/swio_select.sv
module swio_select
    import swio_pkg::*;
#(
    parameter logic [7:0] OWN_ID   = 8'd8,
    parameter logic [7:0] WIN_BASE = 8'h40,
    parameter int         NUM_SW   = 15,
    parameter bit         HI_CHECK = 1'b0,
    parameter logic [7:0] HI_MATCH = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              ext_switch,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              sel_active,
    output logic              speed_slow,
    output logic [NUM_SW-1:0] port_en
);
    localparam int EXT_IDX = 0;

    sel_state_t        st_d, st_q;
    logic              hit_id;
    logic [NUM_SW-1:0] hit_sw;
    logic              ext_wr;
    byte_t             ext_rd;
    logic              matched;

    swio_decode #(
        .WIN_BASE (WIN_BASE),
        .NUM_SW   (NUM_SW),
        .HI_CHECK (HI_CHECK),
        .HI_MATCH (HI_MATCH)
    ) u_decode (
        .addr   (io_addr),
        .hit_id (hit_id),
        .hit_sw (hit_sw)
    );

    // the selection register is shared: every write is stored, match or not
    always_comb begin
        st_d = st_q;
        if (io_wr && hit_id) begin
            st_d.dev_id = io_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dev_id <= ID_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign matched    = (st_q.dev_id == OWN_ID);
    assign sel_active = matched;
    assign ext_wr     = io_wr && matched && hit_sw[EXT_IDX];

    swio_ext_reg u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ext_wr),
        .wr_bit     (io_wdata[EXT_SPEED_BIT]),
        .ext_switch (ext_switch),
        .slow       (speed_slow),
        .rd_byte    (ext_rd)
    );

    assign port_en = hit_sw & {NUM_SW{(io_rd || io_wr) && matched}};

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        if (io_rd && matched) begin
            if (hit_id) begin
                rd_valid = 1'b1;
                rd_data  = ~st_q.dev_id;
            end else if (hit_sw[EXT_IDX]) begin
                rd_valid = 1'b1;
                rd_data  = ext_rd;
            end
        end
    end
endmodule

// File: rtl/swio_select_chk.sv
module swio_select_chk #(
    parameter logic [7:0] OWN_ID   = 8'd8,
    parameter logic [7:0] WIN_BASE = 8'h40,
    parameter int         NUM_SW   = 15,
    parameter bit         HI_CHECK = 1'b0,
    parameter logic [7:0] HI_MATCH = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        rd_data,
    input logic              rd_valid,
    input logic              sel_active,
    input logic              speed_slow,
    input logic [NUM_SW-1:0] port_en
);
    logic id_wr;
    assign id_wr = io_wr && (io_addr[7:0] == WIN_BASE) &&
                   (!HI_CHECK || io_addr[15:8] == HI_MATCH);

    AST_RDV_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> io_rd); // R3
    AST_RDV_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> sel_active); // R3
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == 8'h00)); // R3
    AST_OWN_ID_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr && io_wdata == OWN_ID) |=> sel_active); // R2
    AST_DESELECT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr && (io_wdata == 8'h00 || io_wdata == 8'hFF)) |=> !sel_active); // R4
    AST_SPEED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> $stable(speed_slow)); // R6
    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_en)); // R8
    AST_EN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_en) |-> sel_active); // R8
endmodule

bind swio_select swio_select_chk #(
    .OWN_ID   (OWN_ID),
    .WIN_BASE (WIN_BASE),
    .NUM_SW   (NUM_SW),
    .HI_CHECK (HI_CHECK),
    .HI_MATCH (HI_MATCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .sel_active (sel_active),
    .speed_slow (speed_slow),
    .port_en    (port_en)
);

// File: tb/swio_select_tb.sv
module swio_select_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        ext_switch = 1'b1;

    logic [7:0]  a_data, b_data;
    logic        a_vld, b_vld, a_sel, b_sel, a_slow, b_slow;
    logic [14:0] a_en, b_en;

    int tests = 0, fails = 0;
    bit done = 0;
    string cur_tag = "R1";

    // reference state, one per instance
    int m_id [2];
    int m_slow [2];
    int own [2]  = '{8, 200};
    int hchk [2] = '{0, 1};
    int hval [2] = '{0, 8'h12};

    always #10 clk = ~clk;

    swio_select u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .ext_switch(ext_switch), .rd_data(a_data), .rd_valid(a_vld),
        .sel_active(a_sel), .speed_slow(a_slow), .port_en(a_en));

    swio_select #(.OWN_ID(8'd200), .HI_CHECK(1'b1), .HI_MATCH(8'h12)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .ext_switch(ext_switch), .rd_data(b_data), .rd_valid(b_vld),
        .sel_active(b_sel), .speed_slow(b_slow), .port_en(b_en));

    function automatic bit hit(int i);
        return (hchk[i] == 0) || (int'(io_addr[15:8]) == hval[i]);
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_id[i] = 0; m_slow[i] = 1;
            end else if (io_wr && hit(i)) begin
                if (io_addr[7:0] == 8'h41 && m_id[i] == own[i]) m_slow[i] = int'(io_wdata[0]);
                if (io_addr[7:0] == 8'h40) m_id[i] = int'(io_wdata);
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_one(input int i, input int dat, input int vld, input int sel,
                               input int slow, input int en);
        int  lo = int'(io_addr[7:0]);
        bit  s  = (m_id[i] == own[i]);
        int  ev = 0, ed = 0, ee = 0;
        if (io_rd && hit(i) && s && (lo == 'h40 || lo == 'h41)) begin
            ev = 1;
            ed = (lo == 'h40) ? ((~m_id[i]) & 'hFF) : ((int'(ext_switch) << 7) | m_slow[i]);
        end
        if ((io_rd || io_wr) && hit(i) && s && lo >= 'h41 && lo <= 'h4F) ee = 1 << (lo - 'h41);
        chk($sformatf("u%0d rd_valid", i), vld, ev);
        chk($sformatf("u%0d rd_data", i), dat, ed);
        chk($sformatf("u%0d sel_active", i), sel, int'(s));
        chk($sformatf("u%0d speed_slow", i), slow, m_slow[i]);
        chk($sformatf("u%0d port_en", i), en, ee);
    endtask

    task automatic cyc(input string tag, input logic [15:0] a, input bit r, input bit w,
                       input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = r; io_wr = w; io_wdata = d; cur_tag = tag;
        #5;
        compare_one(0, int'(a_data), int'(a_vld), int'(a_sel), int'(a_slow), int'(a_en));
        compare_one(1, int'(b_data), int'(b_vld), int'(b_sel), int'(b_slow), int'(b_en));
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
        cyc(tag, a, 0, 1, d);
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        cyc(tag, a, 1, 0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, both deselected, speed normal
        rd("R1", 16'h0040); rd("R1", 16'h1240); rd("R1", 16'h0041);
        chk("R1 speed u0 after reset", int'(a_slow), 1);
        // R6: writes to the extension register while deselected
        wr("R6", 16'h0041, 8'h00); wr("R6", 16'h1241, 8'h00); rd("R6", 16'h0041);
        chk("R6 speed unchanged", int'(a_slow), 1);
        // R2 / R9: select u0 with a non-matching upper byte for u_dut_hi
        wr("R9", 16'h0040, 8'd8); rd("R2", 16'h0040); rd("R10", 16'h5540);
        chk("R2 complement", int'(a_data), 8'hF7);
        // R5 / R7: speed fast, bit 7 write ignored
        wr("R5", 16'h0041, 8'h80); rd("R7", 16'h0041);
        ext_switch = 1'b0; rd("R7", 16'h0041);
        wr("R5", 16'hAB41, 8'hFF); rd("R10", 16'h0041);
        wr("R5", 16'h0041, 8'h7E);
        ext_switch = 1'b1; rd("R7", 16'h0041);
        // R8: strobes over all switched ports
        for (int k = 0; k < 15; k++) rd("R8", 16'h0041 + 16'(k));
        for (int k = 0; k < 15; k++) wr("R8", 16'h0041 + 16'(k), 8'h00);
        rd("R8", 16'h0050); rd("R8", 16'h003F);
        // R11: writes just outside the window
        wr("R11", 16'h003F, 8'h00); wr("R11", 16'h0050, 8'h00); rd("R11", 16'h0040);
        // R9: u_dut_hi selected only through upper byte 0x12; u0 loses selection
        wr("R9", 16'h1240, 8'd200); rd("R2", 16'h1240); rd("R9", 16'h0040);
        rd("R9", 16'h0041); wr("R9", 16'h0041, 8'h00); rd("R9", 16'h1241);
        wr("R5", 16'h1241, 8'h00); rd("R7", 16'h1241);
        for (int k = 0; k < 15; k++) rd("R9", 16'h3441 + 16'(k));
        // R4: deselect codes
        wr("R4", 16'h1240, 8'h00); rd("R4", 16'h1240);
        wr("R4", 16'h1240, 8'd200); wr("R4", 16'h1240, 8'hFF); rd("R4", 16'h1240);
        wr("R4", 16'h0040, 8'd8); wr("R4", 16'h0040, 8'hFF); rd("R4", 16'h0040);
        // R3: mixed traffic
        for (int n = 0; n < 600; n++) begin
            logic [7:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[9:7])
                3'd0, 3'd1: d = 8'd8;
                3'd2, 3'd3: d = 8'd200;
                3'd4:       d = 8'h00;
                3'd5:       d = 8'hFF;
                default:    d = lf[7:0] ^ lf[15:8];
            endcase
            ext_switch = lf[4];
            cyc("R3", {(lf[3] ? 8'h12 : 8'h00), 8'h3E + 8'(lf[15:10] % 20)},
                lf[2] & ~lf[1], lf[1], d);
        end
        @(negedge clk); io_rd = 0; io_wr = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule